// File: doc/BRIEF.md
# Memory Write-Protect Control Register

This block keeps the protection settings of a serial memory and answers, for every write the memory is about to perform, whether that write may proceed. It covers writes to the main array, to the one-time-programmable (OTP) page and to the protection register itself. The register holds three settings. A size code reserves a read-only region at the bottom of the array. A polarity bit sets which level of the dynamic write-control pin blocks array writes. A lock bit freezes the register.

Once the lock bit is set, the register accepts new contents only while a dedicated unlock pin is held high. That pin reads low when left floating, so a board that ties it low keeps the settings for good. The register is written one byte per strobe. The write decision is combinational from the current request, and an accepted register write is visible on the readback port after the next clock edge. Reset loads a parameterised default, all zeros by default, which leaves the register unlocked with nothing protected.

Top module: `wprot_ctrl_top`

## Requirements
- R1: After reset the readback port shows RESET_VAL (default 8'h00), and the write-allowed output is low while no request is valid.
- R2: The register layout is: bits [2:0] are the size code, bit 3 is the polarity bit, bit 7 is the lock bit, and bits [6:4] always read 0. A register write while unlocked stores these fields, and they appear on the readback port one cycle after the strobe.
- R3: While the lock bit is 1 and the unlock pin is low, a register write strobe changes nothing in the register.
- R4: While the lock bit is 1 and the unlock pin is high, a register write is accepted, and this includes a write that clears the lock bit.
- R5: Size code n (0 to 7) protects array addresses below 512*n, so code 0 protects nothing. An array write (kind 2'b00) to a protected address is refused at any pin level.
- R6: An array write outside the protected region is refused when the write-control pin is at its blocking level and allowed otherwise. With polarity 0 the blocking level is high, and with polarity 1 it is low.
- R7: An OTP page write (kind 2'b01) is always allowed, whatever the lock bit, size code and write-control pin are.
- R8: A control-register write request (kind 2'b10) is allowed exactly when the lock bit is 0 or the unlock pin is high. The write-control pin has no effect on it.
- R9: The write-allowed output is low whenever no request is valid, and it is low for the reserved kind 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_i | input | 1 | Register write strobe, one byte per cycle |
| reg_wdata_i | input | REG_W (8) | Register write data |
| wr_ctl_pin_i | input | 1 | Level of the dynamic write-control pin |
| unlock_pin_i | input | 1 | Level of the hardware unlock pin (low when floating) |
| acc_valid_i | input | 1 | A write request is being evaluated this cycle |
| acc_kind_i | input | 2 | Write target: 00 array, 01 OTP page, 10 control register, 11 reserved |
| acc_addr_i | input | ADDR_W (12) | Byte address of an array write |
| wr_ok_o | output | 1 | Write allowed for the current request |
| reg_q_o | output | REG_W (8) | Register contents for readback |

## Verification
The assertions assume that pin levels and request fields are stable around each rising edge. They also assume that a control-register write request and its matching strobe are presented in the same cycle, so that the reported grant and the update agree. The bench drives every input on the falling clock edge and holds it for a full cycle. It samples half a cycle later, and it only raises the strobe together with a matching control-register request or with no request at all.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [1:0] {
    KIND_ARRAY = 2'b00,
    KIND_OTP   = 2'b01,
    KIND_CTRL  = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  // Mask of the bits the register really stores: size code, polarity, lock.
  function automatic logic [31:0] keep_mask(input int reg_w, input int code_w);
    logic [31:0] m;
    m = (32'd1 << (code_w + 1)) - 32'd1;
    m = m | (32'd1 << (reg_w - 1));
    return m;
  endfunction

endpackage

// File: rtl/wprot_rst_sync.sv
module wprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wprot_ctrl_reg.sv
module wprot_ctrl_reg
  import wprot_pkg::*;
#(
  parameter int              REG_W     = 8,
  parameter int              CODE_W    = 3,
  parameter logic [REG_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              unlock_i,
  output logic [REG_W-1:0]  reg_q_o,
  output logic [CODE_W-1:0] code_o,
  output logic              pol_o,
  output logic              lock_o,
  output logic              grant_o
);
  localparam logic [31:0]      MASK32 = keep_mask(REG_W, CODE_W);
  localparam logic [REG_W-1:0] MASK   = MASK32[REG_W-1:0];
  localparam int               POL_B  = CODE_W;
  localparam int               LOCK_B = REG_W - 1;

  logic [REG_W-1:0] q;
  logic [REG_W-1:0] d;
  logic             en;

  // next-state
  always_comb begin
    grant_o = !q[LOCK_B] || unlock_i;
    en      = wr_i && grant_o;
    d       = wdata_i & MASK;
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL & MASK;
    else if (en) q <= d;
  end

  assign reg_q_o = q;
  assign code_o  = q[CODE_W-1:0];
  assign pol_o   = q[POL_B];
  assign lock_o  = q[LOCK_B];

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !unlock_i) |=> $stable(reg_q_o)); // R3
  AST_UNLOCK_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && unlock_i) |=> (reg_q_o[CODE_W:0] == $past(wdata_i[CODE_W:0]))); // R4
  AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !lock_o) |=> (lock_o == $past(wdata_i[LOCK_B]))); // R2
endmodule

// File: rtl/wprot_zone_cmp.sv
module wprot_zone_cmp #(
  parameter int ADDR_W    = 12,
  parameter int CODE_W    = 3,
  parameter int ZONE_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              in_zone_o
);
  localparam int LIM_W = CODE_W + ZONE_LOG2;
  localparam int CMP_W = ((ADDR_W > LIM_W) ? ADDR_W : LIM_W) + 1;

  logic [CMP_W-1:0] addr_x;
  logic [CMP_W-1:0] limit_x;

  generate
    if (ZONE_LOG2 == 0) begin : g_unit
      always_comb limit_x = CMP_W'(code_i);
    end else begin : g_shift
      always_comb limit_x = CMP_W'({code_i, {ZONE_LOG2{1'b0}}});
    end
  endgenerate

  always_comb begin
    addr_x    = CMP_W'(addr_i);
    in_zone_o = addr_x < limit_x;
  end
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
  import wprot_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] kind_i,
  input  logic       in_zone_i,
  input  logic       wc_pin_i,
  input  logic       pol_i,
  input  logic       ctrl_grant_i,
  output logic       ok_o
);
  logic wc_block;

  always_comb begin
    wc_block = pol_i ? !wc_pin_i : wc_pin_i;
    ok_o     = 1'b0;
    if (valid_i) begin
      case (acc_kind_e'(kind_i))
        KIND_ARRAY: ok_o = !in_zone_i && !wc_block;
        KIND_OTP:   ok_o = 1'b1;
        KIND_CTRL:  ok_o = ctrl_grant_i;
        default:    ok_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wprot_ctrl_top.sv
module wprot_ctrl_top
  import wprot_pkg::*;
#(
  parameter int               REG_W     = 8,
  parameter int               CODE_W    = 3,
  parameter int               ADDR_W    = 12,
  parameter int               ZONE_LOG2 = 9,
  parameter logic [REG_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              wr_ctl_pin_i,
  input  logic              unlock_pin_i,
  input  logic              acc_valid_i,
  input  logic [1:0]        acc_kind_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              wr_ok_o,
  output logic [REG_W-1:0]  reg_q_o
);
  logic              rst_n_s;
  logic [CODE_W-1:0] code;
  logic              pol;
  logic              lock;
  logic              grant;
  logic              in_zone;

  wprot_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  wprot_ctrl_reg #(.REG_W(REG_W), .CODE_W(CODE_W), .RESET_VAL(RESET_VAL)) u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .unlock_i(unlock_pin_i), .reg_q_o(reg_q_o), .code_o(code), .pol_o(pol),
    .lock_o(lock), .grant_o(grant)
  );

  wprot_zone_cmp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .ZONE_LOG2(ZONE_LOG2)) u_zone (
    .addr_i(acc_addr_i), .code_i(code), .in_zone_o(in_zone)
  );

  wprot_gate u_gate (
    .valid_i(acc_valid_i), .kind_i(acc_kind_i), .in_zone_i(in_zone),
    .wc_pin_i(wr_ctl_pin_i), .pol_i(pol), .ctrl_grant_i(grant), .ok_o(wr_ok_o)
  );

  AST_OTP_OPEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_valid_i && acc_kind_i == KIND_OTP) |-> wr_ok_o); // R7
  AST_ZONE_SHUT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_valid_i && acc_kind_i == KIND_ARRAY && in_zone) |-> !wr_ok_o); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!acc_valid_i || acc_kind_i == KIND_RSVD) |-> !wr_ok_o); // R9
  AST_CTRL_MATCH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc_valid_i && acc_kind_i == KIND_CTRL) |-> (wr_ok_o == grant)); // R8
  AST_LOCK_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lock && !unlock_pin_i) |=> $stable(reg_q_o)); // R3
endmodule

// File: tb/wprot_ctrl_tb.sv
`timescale 1ns/1ps
module wprot_ctrl_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        wc = 1'b0;
  logic        unl = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  kind = '0;
  logic [11:0] addr = '0;
  logic        wr_ok;
  logic [7:0]  reg_q;

  int tests = 0;
  int fails = 0;
  logic [7:0] mreg = 8'h00;

  logic       exp_ok_q[$];
  logic [7:0] exp_reg_q[$];
  int         rid_q[$];
  bit         done = 0;

  always #2.5 clk = ~clk;

  wprot_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .wr_ctl_pin_i(wc), .unlock_pin_i(unl), .acc_valid_i(valid),
    .acc_kind_i(kind), .acc_addr_i(addr), .wr_ok_o(wr_ok), .reg_q_o(reg_q)
  );

  function automatic logic model_ok(logic v, logic [1:0] k, logic [11:0] a,
                                    logic w, logic u);
    int lim;
    logic blk;
    if (!v) return 1'b0;
    case (k)
      2'b00: begin
        lim = 512 * int'(mreg[2:0]);
        blk = mreg[3] ? !w : w;
        return (int'(a) >= lim) && !blk;
      end
      2'b01: return 1'b1;
      2'b10: return !mreg[7] || u;
      default: return 1'b0;
    endcase
  endfunction

  // driver: one cycle of stimulus, expected item pushed to the scoreboard
  task automatic step(input logic rw, input logic [7:0] wd, input logic w,
                      input logic u, input logic v, input logic [1:0] k,
                      input logic [11:0] a, input int rid);
    @(negedge clk);
    reg_wr = rw; wdata = wd; wc = w; unl = u; valid = v; kind = k; addr = a;
    exp_ok_q.push_back(model_ok(v, k, a, w, u));
    exp_reg_q.push_back(mreg);
    rid_q.push_back(rid);
    if (rw && (!mreg[7] || u)) mreg = wd & 8'h8F;
  endtask

  // monitor: compare half a cycle after the drive
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rid_q.size() != 0) begin
        logic eo; logic [7:0] er; int r;
        eo = exp_ok_q.pop_front(); er = exp_reg_q.pop_front(); r = rid_q.pop_front();
        tests++;
        if (wr_ok !== eo || reg_q !== er) begin
          fails++;
          $display("FAIL R%0d: wr_ok=%b reg=%h expected wr_ok=%b reg=%h", r, wr_ok, reg_q, eo, er);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(0, 8'h00, 0, 0, 0, 2'b00, 12'd0, 1);       // R1 reset value
    step(0, 8'h00, 0, 0, 1, 2'b00, 12'd0, 5);       // R5 code 0: nothing protected
    step(0, 8'h00, 1, 0, 1, 2'b00, 12'd100, 6);     // R6 pol 0, pin high blocks
    step(0, 8'h00, 1, 0, 1, 2'b01, 12'd0, 7);       // R7 OTP with pin blocking
    step(1, 8'hF3, 0, 0, 1, 2'b10, 12'd0, 2);       // R2 write size 3 + lock, R8 grant
    step(0, 8'h00, 0, 0, 0, 2'b00, 12'd0, 2);       // R2 readback 83, bits 6:4 zero
    step(0, 8'h00, 0, 0, 1, 2'b00, 12'd1535, 5);    // R5 last protected byte
    step(0, 8'h00, 0, 0, 1, 2'b00, 12'd1536, 5);    // R5 first open byte
    step(1, 8'h00, 0, 0, 1, 2'b10, 12'd0, 8);       // R8 refused while locked
    step(0, 8'h00, 0, 0, 0, 2'b00, 12'd0, 3);       // R3 register unchanged
    step(0, 8'h00, 1, 0, 1, 2'b01, 12'd0, 7);       // R7 OTP while locked
    step(1, 8'h0F, 0, 1, 1, 2'b10, 12'd0, 4);       // R4 unlock pin high accepts
    step(0, 8'h00, 0, 0, 0, 2'b00, 12'd0, 4);       // R4 now 0F
    step(0, 8'h00, 0, 0, 1, 2'b00, 12'd4000, 6);    // R6 pol 1, pin low blocks
    step(0, 8'h00, 1, 0, 1, 2'b00, 12'd4000, 6);    // R6 pol 1, pin high allows
    step(0, 8'h00, 1, 0, 1, 2'b00, 12'd3583, 5);    // R5 code 7 boundary
    step(0, 8'h00, 1, 0, 1, 2'b00, 12'd3584, 5);    // R5 code 7 just above
    step(0, 8'h00, 0, 0, 1, 2'b10, 12'd0, 8);       // R8 pin at blocking level, no effect
    step(0, 8'h00, 0, 0, 1, 2'b11, 12'd0, 9);       // R9 reserved kind
    step(0, 8'h00, 0, 0, 0, 2'b01, 12'd0, 9);       // R9 no request
    for (int i = 0; i < 400; i++) begin
      logic [1:0] k; logic rw; logic u;
      k  = 2'($urandom_range(0, 3));
      rw = (k == 2'b10) ? 1'($urandom_range(0, 1)) : 1'b0;
      u  = ($urandom_range(0, 7) == 0);
      step(rw, 8'($urandom), 1'($urandom_range(0, 1)), u,
           1'($urandom_range(0, 1)), k, 12'($urandom), 5);
    end
    step(0, 8'h00, 0, 0, 0, 2'b00, 12'd0, 2);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule